// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block times each cycle on an external memory bus shared by several chip-select regions. Each region supplies three settings: a 3-bit wait code for reads, a 3-bit wait code for writes, and a recovery-enable bit. A request names a region and says whether it is a read or a write. The sequencer then drives the matching active-low strobe for the number of states the code selects. In the wait-input mode, it instead keeps extending the cycle while an external active-low WAIT line is held.

Some devices release the shared data bus slowly. For these, the sequencer can place one idle turnaround state ahead of an access whose region differs from the region used last. The sequencer takes a new request only while it is idle. It reports a busy level and a one-cycle completion pulse, and the surrounding bus logic uses these to step through its transfers.

Top module: `bus_wait_seq`

## Requirements
- R1: After reset the block is idle: `busy` is 0, `done` is 0, and both `rdStrobeN` and `wrStrobeN` are 1.
- R2: A read drives only `rdStrobeN` low and uses the region's read code. A write drives only `wrStrobeN` low and uses the region's write code. The two strobes are never low together.
- R3: The fixed-length codes set the number of strobe-low states: 3'b001 gives 2, 3'b010 gives 3, 3'b101 gives 4, 3'b110 gives 5 and 3'b111 gives 6. No access is shorter than 2 strobe-low states.
- R4: The reserved codes 3'b000 and 3'b100 behave like 3'b010, giving 3 strobe-low states.
- R5: Code 3'b011 selects wait-input mode. From the second strobe state onward, the access ends in any state where the synchronized WAIT level is high. Each state where that level is low adds one more state, so E low observations give 2+E states.
- R6: WAIT passes through two register stages. The level acted on in strobe state k is the level of `waitN` at the rising edge that began strobe state k-1.
- R7: If the requested region's recovery bit is 1, and a previous access completed to a different region, one state with `busy` high and both strobes high comes before the first strobe state.
- R8: No recovery state is added when the region matches the previous access, when the requested region's recovery bit is 0, or on the first access after reset.
- R9: `busy` rises on the clock edge that accepts a request and falls after the final strobe state. `done` is high for exactly that final state.
- R10: `reqValid` is ignored while `busy` is high. Neither the running access nor the remembered last region changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present; accepted when idle |
| reqRegion | input | IDX_W | Region index of the request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| cfgRdWait | input | 3*NUM_REGIONS | Read wait codes, 3 bits per region, region 0 in the low bits |
| cfgWrWait | input | 3*NUM_REGIONS | Write wait codes, same packing |
| cfgRecEn | input | NUM_REGIONS | Recovery-enable bit per region |
| waitN | input | 1 | Asynchronous active-low wait request |
| rdStrobeN | output | 1 | Active-low read strobe |
| wrStrobeN | output | 1 | Active-low write strobe |
| busy | output | 1 | An access (including a recovery state) is in progress |
| done | output | 1 | One-cycle pulse in the final strobe state |

## Verification
The hardest case to reach is a wait-input stretch of an exact length. The synchronizer delay puts the deciding WAIT level two edges before the state it governs. The stimulus lowers `waitN` in the cycle the request is presented, then raises it at a negedge counted from the acceptance edge, offset by the synchronizer delay, for stretches of 0 to 5 extra states. A second hard case is recovery that depends on history. The stimulus walks accesses across regions with the enable bits set differently, holds a competing request through a busy access, and applies a mid-run reset so that the first access afterwards does not insert a turnaround state.

// File: rtl/bws_pkg.sv
package bws_pkg;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REC  = 2'd1,
    ST_ACC  = 2'd2
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;    // capture request
    logic cntClr;  // counter to first strobe state
    logic cntInc;  // advance one state
    logic commit;  // record completed region
  } seqCtl_t;

  // datapath -> control status
  typedef struct packed {
    logic needRec;  // pending request needs a turnaround state
    logic finish;   // current strobe state is the last
    logic isWrite;  // captured direction
  } seqStat_t;
endpackage

// File: rtl/bws_datapath.sv
module bws_datapath
  import bws_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDX_W-1:0]              reqRegion,
  input  logic                          reqWrite,
  input  logic [CODE_W*NUM_REGIONS-1:0] cfgRdWait,
  input  logic [CODE_W*NUM_REGIONS-1:0] cfgWrWait,
  input  logic [NUM_REGIONS-1:0]        cfgRecEn,
  input  logic                          waitN,
  input  seqCtl_t                       ctl,
  output seqStat_t                      stat
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic                waitMeta, waitSync;
  logic [IDX_W-1:0]    curRegion, lastRegion;
  logic                curWrite, lastValid;
  logic [CNT_W-1:0]    stateCnt;
  logic [CODE_W-1:0]   selCode;
  logic [CNT_W-1:0]    tgtLen;
  logic                pinMode;

  // two-stage synchronizer for the asynchronous wait line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waitMeta <= 1'b1;
      waitSync <= 1'b1;
    end else begin
      waitMeta <= waitN;
      waitSync <= waitMeta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curRegion <= '0;
      curWrite  <= 1'b0;
    end else if (ctl.load) begin
      curRegion <= reqRegion;
      curWrite  <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastRegion <= '0;
      lastValid  <= 1'b0;
    end else if (ctl.commit) begin
      lastRegion <= curRegion;
      lastValid  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stateCnt <= '0;
    else if (ctl.cntClr)
      stateCnt <= CNT_W'(1);
    else if (ctl.cntInc && stateCnt != CNT_MAX)
      stateCnt <= stateCnt + 1'b1;
  end

  assign selCode = curWrite ? cfgWrWait[curRegion*CODE_W +: CODE_W]
                            : cfgRdWait[curRegion*CODE_W +: CODE_W];

  always_comb begin
    pinMode = 1'b0;
    unique case (selCode)
      3'b001:  tgtLen = CNT_W'(2);
      3'b010:  tgtLen = CNT_W'(3);
      3'b101:  tgtLen = CNT_W'(4);
      3'b110:  tgtLen = CNT_W'(5);
      3'b111:  tgtLen = CNT_W'(6);
      3'b011: begin
        tgtLen  = CNT_W'(2);
        pinMode = 1'b1;
      end
      default: tgtLen = CNT_W'(3);  // reserved codes fall back to 3 states
    endcase
  end

  assign stat.finish  = pinMode ? (stateCnt >= CNT_W'(2) && waitSync)
                                : (stateCnt == tgtLen);
  assign stat.isWrite = curWrite;
  assign stat.needRec = cfgRecEn[reqRegion] && lastValid && (reqRegion != lastRegion);
endmodule

// File: rtl/bws_control.sv
module bws_control
  import bws_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reqValid,
  input  seqStat_t stat,
  output seqCtl_t  ctl,
  output logic     rdStrobeN,
  output logic     wrStrobeN,
  output logic     busy,
  output logic     done
);
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        ctl.load   = 1'b1;
        ctl.cntClr = 1'b1;
        nextState  = stat.needRec ? ST_REC : ST_ACC;
      end
      ST_REC: begin
        ctl.cntClr = 1'b1;
        nextState  = ST_ACC;
      end
      ST_ACC: if (stat.finish) begin
        ctl.commit = 1'b1;
        nextState  = ST_IDLE;
      end else begin
        ctl.cntInc = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_ACC) && stat.finish;
  assign rdStrobeN = !((state == ST_ACC) && !stat.isWrite);
  assign wrStrobeN = !((state == ST_ACC) &&  stat.isWrite);
endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq
  import bws_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reqValid,
  input  logic [IDX_W-1:0]              reqRegion,
  input  logic                          reqWrite,
  input  logic [CODE_W*NUM_REGIONS-1:0] cfgRdWait,
  input  logic [CODE_W*NUM_REGIONS-1:0] cfgWrWait,
  input  logic [NUM_REGIONS-1:0]        cfgRecEn,
  input  logic                          waitN,
  output logic                          rdStrobeN,
  output logic                          wrStrobeN,
  output logic                          busy,
  output logic                          done
);
  seqCtl_t  ctl;
  seqStat_t stat;

  bws_datapath #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rst_n(rst_n),
    .reqRegion(reqRegion), .reqWrite(reqWrite),
    .cfgRdWait(cfgRdWait), .cfgWrWait(cfgWrWait), .cfgRecEn(cfgRecEn),
    .waitN(waitN), .ctl(ctl), .stat(stat)
  );

  bws_control ctrl_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .stat(stat), .ctl(ctl),
    .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN), .busy(busy), .done(done)
  );
endmodule

// File: rtl/bus_wait_seq_chk.sv
module bus_wait_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic reqValid,
  input logic rdStrobeN,
  input logic wrStrobeN,
  input logic busy,
  input logic done
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobeN || wrStrobeN)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rdStrobeN && wrStrobeN && !done)); // R1
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R9
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !(rdStrobeN && wrStrobeN))); // R9
  AST_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!rdStrobeN || !wrStrobeN)); // R3
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reqValid) |=> busy); // R9
  AST_REC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rdStrobeN && wrStrobeN) |=> (!rdStrobeN || !wrStrobeN)); // R7
endmodule

bind bus_wait_seq bus_wait_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
  .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN), .busy(busy), .done(done)
);

// File: tb/bus_wait_seq_tb_top.sv
module bus_wait_seq_tb_top;
  localparam int NREG = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqRegion = '0;
  logic reqWrite = 1'b0;
  logic waitN = 1'b1;
  logic [3*NREG-1:0] cfgRdWait, cfgWrWait;
  logic [NREG-1:0] cfgRecEn;
  logic rdStrobeN, wrStrobeN, busy, done;

  logic [2:0] rdCfg [NREG];
  logic [2:0] wrCfg [NREG];
  logic       recCfg[NREG];

  int total = 0;
  int bad = 0;
  int lastReg = -1;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      cfgRdWait[3*i +: 3] = rdCfg[i];
      cfgWrWait[3*i +: 3] = wrCfg[i];
      cfgRecEn[i]         = recCfg[i];
    end
  end

  bus_wait_seq #(.NUM_REGIONS(NREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqRegion(reqRegion),
    .reqWrite(reqWrite), .cfgRdWait(cfgRdWait), .cfgWrWait(cfgWrWait),
    .cfgRecEn(cfgRecEn), .waitN(waitN), .rdStrobeN(rdStrobeN),
    .wrStrobeN(wrStrobeN), .busy(busy), .done(done)
  );

  function automatic int lenOf(logic [2:0] code);
    case (code)
      3'b001: return 2;
      3'b010: return 3;
      3'b101: return 4;
      3'b110: return 5;
      3'b111: return 6;
      default: return 3;
    endcase
  endfunction

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {rdN,wrN,busy,done} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // run one access; expected per-cycle outputs come from the requirements
  task automatic access(input int rg, input bit wr, input int extra,
                        input bit holdReq, input int otherReg, input string tag);
    logic [3:0] expq[$];
    logic [2:0] code;
    bit pin, rec;
    int len, recOff;
    code = wr ? wrCfg[rg] : rdCfg[rg];
    pin  = (code == 3'b011);
    len  = pin ? 2 + extra : lenOf(code);
    rec  = recCfg[rg] && (lastReg >= 0) && (lastReg != rg);
    recOff = rec ? 1 : 0;
    if (rec) expq.push_back(4'b1110);
    for (int k = 1; k <= len; k++)
      expq.push_back({wr ? 1'b1 : 1'b0, wr ? 1'b0 : 1'b1, 1'b1, (k == len)});
    @(negedge clk);
    reqRegion = 2'(rg);
    reqWrite  = wr;
    reqValid  = 1'b1;
    waitN     = (pin && extra > 0) ? 1'b0 : 1'b1;
    @(posedge clk);
    for (int i = 0; i < expq.size(); i++) begin
      @(negedge clk);
      if (holdReq) reqRegion = 2'(otherReg);
      else         reqValid  = 1'b0;
      if (pin && extra > 0 && i == extra - 1 + recOff) waitN = 1'b1;
      check({rdStrobeN, wrStrobeN, busy, done}, expq[i], tag);
    end
    @(negedge clk);
    reqValid = 1'b0;
    check({rdStrobeN, wrStrobeN, busy, done}, 4'b1100, {tag, " end R9"});
    waitN = 1'b1;
    lastReg = rg;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    reqValid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    lastReg = -1;
    @(negedge clk);
    check({rdStrobeN, wrStrobeN, busy, done}, 4'b1100, "R1 reset idle");
  endtask

  initial begin
    logic [2:0] codes[7];
    codes = '{3'b001, 3'b010, 3'b101, 3'b110, 3'b111, 3'b000, 3'b100};
    for (int i = 0; i < NREG; i++) begin
      rdCfg[i] = 3'b010; wrCfg[i] = 3'b010; recCfg[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({rdStrobeN, wrStrobeN, busy, done}, 4'b1100, "R1 reset idle");

    // R2 R3 R4: read codes on region 0
    foreach (codes[c]) begin
      rdCfg[0] = codes[c];
      access(0, 1'b0, 0, 1'b0, 0, (c >= 5) ? "R4 reserved read" : "R3 R2 read code");
    end
    // R2 R3 R4 R8: write codes on region 1 (recovery bit clear)
    foreach (codes[c]) begin
      wrCfg[1] = codes[c];
      access(1, 1'b1, 0, 1'b0, 0, (c >= 5) ? "R4 reserved write" : "R3 R2 write code R8");
    end
    // R5 R6: wait-input stretch 0..5
    rdCfg[2] = 3'b011;
    wrCfg[2] = 3'b011;
    for (int e = 0; e <= 5; e++) access(2, 1'b0, e, 1'b0, 0, "R5 R6 wait stretch read");
    access(2, 1'b1, 3, 1'b0, 0, "R5 R6 wait stretch write");

    // R7 R8: recovery
    recCfg[3] = 1'b1;
    access(3, 1'b0, 0, 1'b0, 0, "R7 region change");
    access(3, 1'b1, 0, 1'b0, 0, "R8 same region");
    access(0, 1'b0, 0, 1'b0, 0, "R8 bit clear");
    access(3, 1'b0, 0, 1'b0, 0, "R7 return");
    recCfg[2] = 1'b1;
    access(2, 1'b0, 2, 1'b0, 0, "R7 R5 rec then stretch");

    // R10: competing request held through a busy access
    access(3, 1'b1, 0, 1'b1, 0, "R10 ignored while busy R7");
    access(3, 1'b0, 0, 1'b0, 0, "R10 last region kept R8");

    // R8: first access after reset has no turnaround
    doReset();
    access(3, 1'b0, 0, 1'b0, 0, "R8 first after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: R9 run hung, actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule